// File: doc/BRIEF.md
# Gated Six-Decade BCD Frequency Counter

This block measures a pulse rate by counting the rising edges of an asynchronous pulse input while a gate input is high. The gate comes from a time base that runs on the same clock. The count is kept in a chain of decimal decades. Each decade wraps from 9 back to 0 and passes a carry to the next one. When the gate drops, the block copies the decades into a held result register and then clears the decades. The next window therefore starts from zero.

A flag reports when the count ran past the top decade during the last window. The flag is produced at the same moment as the result, so the two always describe the same window.

A lock request lets the system keep the displayed value. The first window that completes with the request high still loads its result. After that, the result register and the flag are held until the request drops. The decades go on counting and clearing as usual during this time.

The environment must keep the gate low for at least three clock cycles between windows. The pulse input must stay in each level for at least one clock cycle.

Top module: `gated_bcd_counter`

## Requirements
- R1: After reset, disp_bcd is all zero and over_flag and cap_stb are low.
- R2: Each rising edge of pulse_in seen while gate_in is high adds one to the count. The captured result is the count modulo 10^DIGITS. Digit i sits in disp_bcd[4i+3:4i], with the least significant digit in bits 3:0.
- R3: Rising edges of pulse_in that occur while gate_in is low are not counted.
- R4: cap_stb is high for exactly one clock cycle. That cycle starts at the first clock edge that samples gate_in low after it was high. The new result appears on disp_bcd at the end of that cycle.
- R5: The decades are cleared one cycle after the transfer. Each window's result depends only on that window's pulses.
- R6: disp_bcd and over_flag change only at the end of a cap_stb cycle, and hold their value otherwise.
- R7: over_flag is set at a capture if the top decade carried at least once during that window. It is cleared at a capture if the top decade did not carry.
- R8: A pulse whose rising edge comes just before gate_in falls is counted once or not at all. The result is never off by any other amount.
- R9: While lock_req is high, the first capture still loads the result. Later gate falls give no cap_stb, and disp_bcd and over_flag stay unchanged until lock_req goes low.
- R10: Every four-bit digit of disp_bcd and of the internal decades is always in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gate_in | input | 1 | Count window, synchronous to clk |
| pulse_in | input | 1 | Asynchronous pulse stream to be counted |
| lock_req | input | 1 | Request to hold the displayed result |
| disp_bcd | output | 4*DIGITS (24) | Held result, BCD, least significant digit in bits 3:0 |
| over_flag | output | 1 | Top decade carried during the last captured window |
| cap_stb | output | 1 | One-cycle strobe for the transfer into disp_bcd |

## Verification
The bench targets five situations:
- Windows of exactly 999, 1000 and 1234 pulses on a three-decade build. Here a carry chain that ripples wrong, or a flag that is not re-armed, gives a wrong digit or a stale overflow.
- Pulse bursts placed inside the gaps between windows. These expose input gating that leaks counts.
- A window that follows a large count. A design that captures after clearing, or never clears, shows zero or an accumulated total.
- A pulse placed right at the gate fall, which must give N or N+1 and nothing else.
- Lock sequences, where a design that ignores the hold updates the display or raises a strobe.

// File: rtl/gbc_pkg.sv
package gbc_pkg;
  localparam int unsigned BCD_W = 4;

  typedef logic [BCD_W-1:0] bcd_t;

  function automatic bcd_t bcd_next(input bcd_t d);
    return (d == bcd_t'(9)) ? bcd_t'(0) : bcd_t'(d + bcd_t'(1));
  endfunction

  function automatic logic bcd_is_top(input bcd_t d);
    return d == bcd_t'(9);
  endfunction

  function automatic logic bcd_valid(input bcd_t d);
    return d <= bcd_t'(9);
  endfunction
endpackage

// File: rtl/gbc_pulse_sync.sv
module gbc_pulse_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic rise_stb
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], raw_in};
      prev_q <= sync_q[LAST];
    end
  end

  assign rise_stb = sync_q[LAST] & ~prev_q;
endmodule

// File: rtl/gbc_decade.sv
module gbc_decade
  import gbc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output bcd_t digit,
  output logic carry
);
  bcd_t digit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    digit_q <= '0;
    else if (clr)  digit_q <= '0;
    else if (step) digit_q <= bcd_next(digit_q);
  end

  assign digit = digit_q;
  assign carry = step & ~clr & bcd_is_top(digit_q);
endmodule

// File: rtl/gbc_window_ctrl.sv
module gbc_window_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_in,
  input  logic lock_req,
  input  logic top_carry,
  output logic xfer_stb,
  output logic clr_stb,
  output logic ovf_flag,
  output logic hold_q
);
  logic gate_q;
  logic gate_fall;
  logic gate_rise;
  logic fall_q;
  logic clr_q;
  logic armed_q;
  logic ovf_q;
  logic lockd_q;

  assign gate_fall = gate_q & ~gate_in;
  assign gate_rise = ~gate_q & gate_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      fall_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      gate_q <= gate_in;
      fall_q <= gate_fall;
      clr_q  <= fall_q;
    end
  end

  assign xfer_stb = fall_q & ~lockd_q;
  assign clr_stb  = clr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed_q <= 1'b1;
    else if (top_carry) armed_q <= 1'b0;
    else if (gate_rise) armed_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_q <= 1'b0;
    else if (xfer_stb) ovf_q <= ~armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lockd_q <= 1'b0;
    else if (!lock_req) lockd_q <= 1'b0;
    else if (xfer_stb) lockd_q <= 1'b1;
  end

  assign ovf_flag = ovf_q;
  assign hold_q   = lockd_q;
endmodule

// File: rtl/gated_bcd_counter.sv
module gated_bcd_counter
  import gbc_pkg::*;
#(
  parameter int unsigned DIGITS      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  gate_in,
  input  logic                  pulse_in,
  input  logic                  lock_req,
  output logic [4*DIGITS-1:0]   disp_bcd,
  output logic                  over_flag,
  output logic                  cap_stb
);
  localparam int unsigned VEC_W = BCD_W * DIGITS;

  logic              pulse_rise;
  logic              count_step;
  logic              clr_stb;
  logic              hold_q;
  logic [DIGITS:0]   step_chain;
  logic [DIGITS-1:0] carry_vec;
  logic [VEC_W-1:0]  count_vec;
  logic [VEC_W-1:0]  store_q;

  gbc_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (pulse_in),
    .rise_stb (pulse_rise)
  );

  assign count_step    = pulse_rise & gate_in;
  assign step_chain[0] = count_step;

  for (genvar gi = 0; gi < DIGITS; gi++) begin : g_dec
    bcd_t dig;
    gbc_decade u_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_stb),
      .step  (step_chain[gi]),
      .digit (dig),
      .carry (carry_vec[gi])
    );
    assign step_chain[gi+1]            = carry_vec[gi];
    assign count_vec[BCD_W*gi +: BCD_W] = dig;
  end

  gbc_window_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_in   (gate_in),
    .lock_req  (lock_req),
    .top_carry (step_chain[DIGITS]),
    .xfer_stb  (cap_stb),
    .clr_stb   (clr_stb),
    .ovf_flag  (over_flag),
    .hold_q    (hold_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       store_q <= '0;
    else if (cap_stb) store_q <= count_vec;
  end

  assign disp_bcd = store_q;
endmodule

// File: rtl/gbc_checker.sv
module gbc_checker #(
  parameter int unsigned DIGITS = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                gate_in,
  input logic                cap_stb,
  input logic                clr_stb,
  input logic                over_flag,
  input logic [4*DIGITS-1:0] disp_bcd,
  input logic [4*DIGITS-1:0] count_vec
);
  AST_CAPTURE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> !cap_stb); // R4

  AST_CAPTURE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |-> (!$past(gate_in) && $past(gate_in, 2))); // R4

  AST_CLEAR_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> (count_vec == '0)); // R5

  AST_NO_COUNT_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(gate_in) && !$past(clr_stb)) |-> $stable(count_vec)); // R3

  AST_DISPLAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cap_stb) |-> $stable(disp_bcd)); // R6

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cap_stb) |-> $stable(over_flag)); // R7

  always @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < DIGITS; i++) begin
        AST_DIGITS_BCD: assert (disp_bcd[4*i +: 4] <= 4'd9 && count_vec[4*i +: 4] <= 4'd9); // R10
      end
    end
  end
endmodule

bind gated_bcd_counter gbc_checker #(.DIGITS(DIGITS)) u_gbc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .gate_in   (gate_in),
  .cap_stb   (cap_stb),
  .clr_stb   (clr_stb),
  .over_flag (over_flag),
  .disp_bcd  (disp_bcd),
  .count_vec (count_vec)
);

// File: tb/test_gated_bcd_counter.sv
module test_gated_bcd_counter;
  localparam int CLK_PERIOD = 10;
  localparam int D          = 3;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           gate_in;
  logic           pulse_in;
  logic           lock_req;
  logic [4*D-1:0] disp_bcd;
  logic           over_flag;
  logic           cap_stb;

  int checks = 0;
  int errors = 0;
  logic [4*D-1:0] shown_exp;
  logic           flag_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  gated_bcd_counter #(.DIGITS(D)) i_gated_bcd_counter (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .pulse_in(pulse_in),
    .lock_req(lock_req), .disp_bcd(disp_bcd), .over_flag(over_flag), .cap_stb(cap_stb)
  );

  function automatic logic [4*D-1:0] to_bcd(input int n);
    logic [4*D-1:0] v;
    int rem;
    rem = n;
    for (int i = 0; i < D; i++) begin
      v[4*i +: 4] = 4'(rem % 10);
      rem = rem / 10;
    end
    return v;
  endfunction

  function automatic int modulus();
    int m;
    m = 1;
    for (int i = 0; i < D; i++) m = m * 10;
    return m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulses(input int n, input int hi, input int lo);
    for (int k = 0; k < n; k++) begin
      pulse_in = 1'b1;
      repeat (hi) @(negedge clk);
      pulse_in = 1'b0;
      repeat (lo) @(negedge clk);
    end
  endtask

  // Gap between windows, with stray pulses that must be ignored (R3).
  task automatic gap(input int stray);
    repeat (2) @(negedge clk);
    pulses(stray, 1, 2);
    repeat (4) @(negedge clk);
  endtask

  // One gate window of n pulses; checks the strobe timing and the result.
  task automatic window(input int n, input int hi, input int lo, input logic expect_cap,
                        input string req);
    gate_in = 1'b1;
    repeat (2) @(negedge clk);
    pulses(n, hi, lo);
    repeat (4) @(negedge clk);
    gate_in = 1'b0;
    if (expect_cap) begin
      shown_exp = to_bcd(n % modulus());
      flag_exp  = (n >= modulus());
    end
    @(negedge clk);
    check({req, " R4 strobe"}, 32'(cap_stb), 32'(expect_cap));
    @(negedge clk);
    check({req, " R4 strobe width"}, 32'(cap_stb), 32'd0);
    check({req, " digits"}, 32'(disp_bcd), 32'(shown_exp));
    check({req, " R7 flag"}, 32'(over_flag), 32'(flag_exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n0;
    int pre;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; gate_in = 1'b0; pulse_in = 1'b0; lock_req = 1'b0;
    shown_exp = '0; flag_exp = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 digits", 32'(disp_bcd), 32'd0);
    check("R1 flag", 32'(over_flag), 32'd0);
    check("R1 strobe", 32'(cap_stb), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    window(7, 1, 1, 1'b1, "R2 basic");
    gap(5);
    window(0, 1, 1, 1'b1, "R5 empty after count");
    gap(3);
    window(999, 1, 1, 1'b1, "R2 full no carry");
    gap(0);
    window(1000, 1, 1, 1'b1, "R7 carry wrap");
    gap(2);
    window(12, 2, 3, 1'b1, "R7 flag cleared");
    gap(0);
    window(1234, 1, 1, 1'b1, "R7 carry with residue");
    gap(4);
    window(3, 1, 1, 1'b1, "R5 restart from zero");

    for (int r = 0; r < 10; r++) begin
      gap(int'($urandom_range(0, 6)));
      window(int'($urandom_range(0, 60)), int'($urandom_range(1, 3)),
             int'($urandom_range(1, 3)), 1'b1, "R2 random");
    end

    // R8: pulse rising right at the gate fall.
    for (int s = 0; s < 3; s++) begin
      gap(1);
      n0 = int'($urandom_range(1, 20));
      gate_in = 1'b1;
      repeat (2) @(negedge clk);
      pulses(n0, 1, 1);
      repeat (4) @(negedge clk);
      pulse_in = 1'b1;
      repeat (s) @(negedge clk);
      gate_in = 1'b0;
      @(negedge clk);
      check("R8 strobe", 32'(cap_stb), 32'd1);
      @(negedge clk);
      checks++;
      if (disp_bcd !== to_bcd(n0) && disp_bcd !== to_bcd(n0 + 1)) begin
        errors++;
        $display("FAIL R8 actual=%0h expected=%0h or %0h", disp_bcd, to_bcd(n0), to_bcd(n0 + 1));
      end
      shown_exp = disp_bcd;
      flag_exp  = 1'b0;
      pulse_in = 1'b0;
      repeat (3) @(negedge clk);
    end

    // R9: lock hold sequence.
    gap(0);
    lock_req = 1'b1;
    window(21, 1, 2, 1'b1, "R9 first capture under lock");
    pre = 21;
    gap(3);
    window(1003, 1, 1, 1'b0, "R9 held");
    gap(1);
    window(8, 1, 1, 1'b0, "R9 still held");
    check("R9 held value", 32'(disp_bcd), 32'(to_bcd(pre)));
    lock_req = 1'b0;
    gap(0);
    window(44, 1, 1, 1'b1, "R9 released");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule